// File: doc/BRIEF.md
# Byte-Lane Synchronous Memory Data Path with Pipelined Turn-Off

This block is a small synchronous single-port memory with four byte lanes and a clocked command interface. On each rising clock edge it takes an address, a word of write data, three chip-select inputs and a set of write controls. A selected cycle with no lane to write is a read. The shared data bus is split into a data-in port, a data-out port and a drive flag that tells the surrounding logic when the outputs would be driving.

A run-time mode input sets the read latency. In flow-through mode the array read register goes straight to the outputs. In pipeline mode one more output register is added. The drive flag comes from a valid bit that travels through the same stages as the read data. A deselect therefore stops the outputs exactly as late as a read would start them. An asynchronous active-low output enable and an active-high sleep input both gate the drive flag. Sleep also blocks new accesses. The stored contents are kept through sleep.

Top module: `burst_sram_dp`

## Requirements
- R1: All synchronous inputs are sampled on the rising edge. A cycle is selected only when `ce_a_ni`=0, `ce_b_ni`=0 and `ce_c_i`=1; any other combination neither writes nor drives.
- R2: With `pipe_mode_i`=0 (flow-through), a read sampled at edge k drives its data between edges k+1 and k+2.
- R3: With `pipe_mode_i`=1 (pipeline), a read sampled at edge k drives its data between edges k+2 and k+3. Back-to-back reads deliver one word per clock.
- R4: When `byte_wr_ni`=0, byte lane n (`data_i[8n+7:8n]`) is written if `lane_wr_ni[n]`=0, and lanes with `lane_wr_ni[n]`=1 keep their contents. `byte_wr_ni`=0 with all lanes at 1 is a read.
- R5: `all_wr_ni`=0 writes all four lanes, whatever the values of `byte_wr_ni` and `lane_wr_ni`.
- R6: After a deselect sampled at edge k, `drive_o` is low from edge k+2 in pipeline mode and from edge k+1 in flow-through mode.
- R7: A write never drives. `drive_o` is low in the output slot that belongs to a write.
- R8: `drive_o` is the internal enable ANDed with `!out_en_ni` and `!sleep_i`, with no clock in between. `data_o` is zero whenever `drive_o` is low.
- R9: Commands sampled while `sleep_i`=1 are ignored, and the stored contents are kept.
- R10: A read sampled on the edge after a write to the same address returns the newly written data.
- R11: After reset, `drive_o`=0 and `data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | 1 = pipeline read, 0 = flow-through read |
| ce_a_ni | input | 1 | Chip select, active low |
| ce_b_ni | input | 1 | Chip select, active low |
| ce_c_i | input | 1 | Chip select, active high |
| addr_i | input | AW | Word address |
| all_wr_ni | input | 1 | Write all lanes, active low |
| byte_wr_ni | input | 1 | Per-lane write qualifier, active low |
| lane_wr_ni | input | 4 | Lane write enables, active low |
| data_i | input | 32 | Write data |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep, active high |
| data_o | output | 32 | Read data, zero when not driving |
| drive_o | output | 1 | Output drive flag |

## Verification
Two pairs of events can fall in the same cycle. In the first, a write commits to the array on the same edge that the next command, a read of the same address, is registered. The bench issues the write and the read back to back and expects the new word. In the second, the turn-off that follows a deselect or a write can land right after the output slot of a read. The bench places a deselect or a write directly behind a read in each mode. It then checks that the flag is high in the read's slot and low exactly one slot later.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned NUM_LANES = 4;

  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/burst_sram_cmd.sv
module burst_sram_cmd #(
  parameter int unsigned AW = 4,
  parameter int unsigned NL = 4,
  parameter int unsigned LW = 8,
  localparam int unsigned DW = NL * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_a_ni,
  input  logic          ce_b_ni,
  input  logic          ce_c_i,
  input  logic          sleep_i,
  input  logic          all_wr_ni,
  input  logic          byte_wr_ni,
  input  logic [NL-1:0] lane_wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          rd_o,
  output logic [NL-1:0] wmask_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  logic          sel;
  logic [NL-1:0] mask_d;

  assign sel = !ce_a_ni && !ce_b_ni && ce_c_i && !sleep_i;

  // global write overrides lane controls
  always_comb begin
    if (!all_wr_ni)       mask_d = '1;
    else if (!byte_wr_ni) mask_d = ~lane_wr_ni;
    else                  mask_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_o    <= 1'b0;
      wmask_o <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      rd_o    <= sel && (mask_d == '0);
      wmask_o <= sel ? mask_d : '0;
      if (sel) begin
        addr_o  <= addr_i;
        wdata_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW = 4,
  parameter int unsigned NL = 4,
  parameter int unsigned LW = 8,
  localparam int unsigned DW = NL * LW
) (
  input  logic          clk_i,
  input  logic          rd_i,
  input  logic [NL-1:0] wmask_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (wmask_i[g]) mem[addr_i] <= wdata_i[g*LW +: LW];
      if (rd_i)       rd_q        <= mem[addr_i];
    end

    assign rd_data_o[g*LW +: LW] = rd_q;
  end
endmodule

// File: rtl/burst_sram_out.sv
module burst_sram_out
  import burst_sram_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [DW-1:0] rd_data_i,
  input  rd_mode_e      mode_i,
  input  logic          out_en_ni,
  input  logic          sleep_i,
  output logic [DW-1:0] data_o,
  output logic          drive_o
);
  logic          rd_v_q;
  logic          out_v_q;
  logic [DW-1:0] out_q;
  logic          en_int;
  logic [DW-1:0] data_sel;

  // valid travels alongside data so turn-off matches read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_v_q  <= 1'b0;
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else begin
      rd_v_q  <= rd_i;
      out_v_q <= rd_v_q;
      if (rd_v_q) out_q <= rd_data_i;
    end
  end

  always_comb begin
    if (mode_i == RD_PIPE) begin
      en_int   = out_v_q;
      data_sel = out_q;
    end else begin
      en_int   = rd_v_q;
      data_sel = rd_data_i;
    end
  end

  assign drive_o = en_int && !out_en_ni && !sleep_i;
  assign data_o  = drive_o ? data_sel : '0;
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned NL = NUM_LANES,
  localparam int unsigned DW = NUM_LANES * LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pipe_mode_i,
  input  logic          ce_a_ni,
  input  logic          ce_b_ni,
  input  logic          ce_c_i,
  input  logic [AW-1:0] addr_i,
  input  logic          all_wr_ni,
  input  logic          byte_wr_ni,
  input  logic [NL-1:0] lane_wr_ni,
  input  logic [DW-1:0] data_i,
  input  logic          out_en_ni,
  input  logic          sleep_i,
  output logic [DW-1:0] data_o,
  output logic          drive_o
);
  logic          cmd_rd;
  logic [NL-1:0] cmd_wmask;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic [DW-1:0] arr_data;
  rd_mode_e      mode;

  assign mode = pipe_mode_i ? RD_PIPE : RD_FLOW;

  burst_sram_cmd #(.AW(AW), .NL(NL), .LW(LANE_W)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_a_ni    (ce_a_ni),
    .ce_b_ni    (ce_b_ni),
    .ce_c_i     (ce_c_i),
    .sleep_i    (sleep_i),
    .all_wr_ni  (all_wr_ni),
    .byte_wr_ni (byte_wr_ni),
    .lane_wr_ni (lane_wr_ni),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .rd_o       (cmd_rd),
    .wmask_o    (cmd_wmask),
    .addr_o     (cmd_addr),
    .wdata_o    (cmd_wdata)
  );

  burst_sram_array #(.DEPTH(DEPTH), .AW(AW), .NL(NL), .LW(LANE_W)) u_array (
    .clk_i     (clk_i),
    .rd_i      (cmd_rd),
    .wmask_i   (cmd_wmask),
    .addr_i    (cmd_addr),
    .wdata_i   (cmd_wdata),
    .rd_data_o (arr_data)
  );

  burst_sram_out #(.DW(DW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (cmd_rd),
    .rd_data_i (arr_data),
    .mode_i    (mode),
    .out_en_ni (out_en_ni),
    .sleep_i   (sleep_i),
    .data_o    (data_o),
    .drive_o   (drive_o)
  );
endmodule

// File: rtl/burst_sram_dp_chk.sv
module burst_sram_dp_chk #(
  parameter int unsigned NL = 4,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pipe_mode_i,
  input logic          ce_a_ni,
  input logic          ce_b_ni,
  input logic          ce_c_i,
  input logic          all_wr_ni,
  input logic          byte_wr_ni,
  input logic [NL-1:0] lane_wr_ni,
  input logic          out_en_ni,
  input logic          sleep_i,
  input logic [DW-1:0] data_o,
  input logic          drive_o
);
  logic [1:0] since_q;
  logic       sel_w, wr_w, rd_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_q <= 2'd0;
    else if (since_q != 2'd3) since_q <= since_q + 2'd1;
  end

  assign sel_w = !ce_a_ni && !ce_b_ni && ce_c_i && !sleep_i;
  assign wr_w  = sel_w && (!all_wr_ni || (!byte_wr_ni && (lane_wr_ni != '1)));
  assign rd_w  = sel_w && !wr_w;

  // R8
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_ni || sleep_i) |-> !drive_o);

  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (data_o == '0));

  // R6
  pipe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q == 2'd3 && pipe_mode_i && !$past(sel_w, 3)) |-> !drive_o);

  // R6
  flow_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2 && !pipe_mode_i && !$past(sel_w, 2)) |-> !drive_o);

  // R7
  wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q == 2'd3 && pipe_mode_i && $past(wr_w, 3)) |-> !drive_o);

  // R2
  flow_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2 && !pipe_mode_i && !out_en_ni && !sleep_i && $past(rd_w, 2)) |-> drive_o);
endmodule

bind burst_sram_dp burst_sram_dp_chk #(.NL(NL), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pipe_mode_i (pipe_mode_i),
  .ce_a_ni     (ce_a_ni),
  .ce_b_ni     (ce_b_ni),
  .ce_c_i      (ce_c_i),
  .all_wr_ni   (all_wr_ni),
  .byte_wr_ni  (byte_wr_ni),
  .lane_wr_ni  (lane_wr_ni),
  .out_en_ni   (out_en_ni),
  .sleep_i     (sleep_i),
  .data_o      (data_o),
  .drive_o     (drive_o)
);

// File: tb/sim_burst_sram_dp.sv
`timescale 1ns/1ps
module sim_burst_sram_dp;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pipe_mode_i = 1'b1;
  logic        ce_a_ni = 1'b1, ce_b_ni = 1'b1, ce_c_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic        all_wr_ni = 1'b1, byte_wr_ni = 1'b1;
  logic [3:0]  lane_wr_ni = 4'hF;
  logic [31:0] data_i = '0;
  logic        out_en_ni = 1'b0, sleep_i = 1'b0;
  logic [31:0] data_o;
  logic        drive_o;

  int total = 0;
  int bad = 0;
  logic [31:0] ref_mem [DEPTH];

  always #2.5 clk_i = ~clk_i;

  burst_sram_dp #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pipe_mode_i(pipe_mode_i),
    .ce_a_ni(ce_a_ni), .ce_b_ni(ce_b_ni), .ce_c_i(ce_c_i),
    .addr_i(addr_i), .all_wr_ni(all_wr_ni), .byte_wr_ni(byte_wr_ni),
    .lane_wr_ni(lane_wr_ni), .data_i(data_i), .out_en_ni(out_en_ni),
    .sleep_i(sleep_i), .data_o(data_o), .drive_o(drive_o)
  );

  task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step_raw(input logic ca, input logic cb, input logic cc, input logic aw,
                          input logic bw, input logic [3:0] ln, input logic [AW-1:0] a,
                          input logic [31:0] d);
    ce_a_ni = ca; ce_b_ni = cb; ce_c_i = cc;
    all_wr_ni = aw; byte_wr_ni = bw; lane_wr_ni = ln; addr_i = a; data_i = d;
    @(negedge clk_i);
  endtask

  task automatic idle();
    step_raw(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step_raw(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, a, '0);
  endtask

  task automatic wr_all(input logic [AW-1:0] a, input logic [31:0] d);
    step_raw(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, a, d);
    if (!sleep_i) ref_mem[a] = d;
  endtask

  task automatic wr_lanes(input logic [AW-1:0] a, input logic [3:0] ln, input logic [31:0] d);
    step_raw(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, ln, a, d);
    for (int n = 0; n < 4; n++)
      if (!ln[n]) ref_mem[a][n*8 +: 8] = d[n*8 +: 8];
  endtask

  task automatic read_check(input logic [AW-1:0] a, input string req);
    rd(a);
    idle();
    if (pipe_mode_i) idle();
    check_val(req, {31'd0, drive_o}, 32'd1);
    check_val(req, data_o, ref_mem[a]);
    idle();
  endtask

  task automatic t_reset();
    check_val("R11 drive", {31'd0, drive_o}, 32'd0);
    check_val("R11 data", data_o, 32'd0);
  endtask

  task automatic t_pipe_read();
    pipe_mode_i = 1'b1;
    wr_all(4'd3, 32'hCAFE0003);
    idle();
    rd(4'd3);
    idle();
    check_val("R3 early", {31'd0, drive_o}, 32'd0);
    idle();
    check_val("R3 drive", {31'd0, drive_o}, 32'd1);
    check_val("R3 data", data_o, 32'hCAFE0003);
    idle();
    check_val("R6 pipe off", {31'd0, drive_o}, 32'd0);
  endtask

  task automatic t_flow_read();
    pipe_mode_i = 1'b0;
    wr_all(4'd5, 32'h5A5A0005);
    idle();
    rd(4'd5);
    idle();
    check_val("R2 drive", {31'd0, drive_o}, 32'd1);
    check_val("R2 data", data_o, 32'h5A5A0005);
    idle();
    check_val("R6 flow off", {31'd0, drive_o}, 32'd0);
    pipe_mode_i = 1'b1;
  endtask

  task automatic t_burst();
    pipe_mode_i = 1'b1;
    for (int i = 0; i < 4; i++) wr_all(AW'(i), 32'h1000_0000 + i * 32'h111);
    idle();
    for (int i = 0; i < 6; i++) begin
      if (i < 4) rd(AW'(i)); else idle();
      if (i >= 2) check_val("R3 burst", data_o, ref_mem[i-2]);
    end
    idle();
    check_val("R6 burst off", {31'd0, drive_o}, 32'd0);
  endtask

  task automatic t_bytes();
    wr_all(4'd7, 32'h11223344);
    wr_lanes(4'd7, 4'b1010, 32'hAABBCCDD);
    idle();
    read_check(4'd7, "R4 lanes");
    check_val("R4 merged", ref_mem[7], 32'h11BB33DD);
    step_raw(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 4'd7, 32'hFFFFFFFF);
    idle(); idle();
    read_check(4'd7, "R4 no lanes");
  endtask

  task automatic t_global();
    step_raw(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 4'd8, 32'h88887777);
    ref_mem[8] = 32'h88887777;
    idle();
    read_check(4'd8, "R5 ignore bw");
    step_raw(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0101, 4'd8, 32'h01020304);
    ref_mem[8] = 32'h01020304;
    idle();
    read_check(4'd8, "R5 ignore lanes");
  endtask

  task automatic t_enables();
    pipe_mode_i = 1'b1;
    wr_all(4'd9, 32'h00009999);
    idle();
    for (int k = 0; k < 3; k++) begin
      step_raw(k == 0, k == 1, k != 2, 1'b0, 1'b1, 4'hF, 4'd9, 32'hDEAD0000 | k);
      step_raw(k == 0, k == 1, k != 2, 1'b1, 1'b1, 4'hF, 4'd9, '0);
      idle();
      idle();
      check_val("R1 no drive", {31'd0, drive_o}, 32'd0);
      read_check(4'd9, "R1 no write");
    end
  endtask

  task automatic t_wr_quiet();
    pipe_mode_i = 1'b1;
    rd(4'd3);
    wr_all(4'd11, 32'hBEEF000B);
    idle();
    check_val("R7 read slot", {31'd0, drive_o}, 32'd1);
    idle();
    check_val("R7 write slot", {31'd0, drive_o}, 32'd0);
  endtask

  task automatic t_raw();
    pipe_mode_i = 1'b1;
    wr_all(4'd12, 32'h0000C0DE);
    idle();
    wr_all(4'd12, 32'h1234ABCD);
    read_check(4'd12, "R10 pipe");
    pipe_mode_i = 1'b0;
    wr_all(4'd12, 32'h7777AAAA);
    read_check(4'd12, "R10 flow");
    pipe_mode_i = 1'b1;
  endtask

  task automatic t_oe();
    pipe_mode_i = 1'b1;
    rd(4'd3);
    idle(); idle();
    out_en_ni = 1'b1;
    #0.5;
    check_val("R8 oe off", {31'd0, drive_o}, 32'd0);
    check_val("R8 oe data", data_o, 32'd0);
    out_en_ni = 1'b0;
    #0.5;
    check_val("R8 oe back", data_o, ref_mem[3]);
    idle();
  endtask

  task automatic t_sleep();
    pipe_mode_i = 1'b1;
    wr_all(4'd10, 32'hA0A0A0A0);
    idle();
    sleep_i = 1'b1;
    wr_all(4'd10, 32'h0BAD0BAD);
    rd(4'd10);
    idle(); idle();
    sleep_i = 1'b0;
    #0.5;
    check_val("R9 sleep read", {31'd0, drive_o}, 32'd0);
    idle();
    read_check(4'd10, "R9 retained");
    rd(4'd10);
    idle(); idle();
    sleep_i = 1'b1;
    #0.5;
    check_val("R8 sleep gate", {31'd0, drive_o}, 32'd0);
    sleep_i = 1'b0;
    #0.5;
    check_val("R8 sleep back", {31'd0, drive_o}, 32'd1);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_pipe_read();
    t_flow_read();
    t_burst();
    t_bytes();
    t_global();
    t_enables();
    t_wr_quiet();
    t_raw();
    t_oe();
    t_sleep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule